// File: doc/BRIEF.md
# Audio Serial Data Formatter

This block sits between the parallel audio datapath and a two-phase serial audio link. The link is paced by an externally supplied bit clock and frame clock, which the block oversamples with its own system clock. Every frame carries one transmit (DAC-path) word on the serial output and one receive (ADC-path) word on the serial input. Three framings are supported: right-justified, left-justified and the one-bit-delayed I2S framing. Each path has its own control that picks whether its word uses the left or the right half of the frame.

The word length comes from a two-bit field. An 8-bit enable takes priority over that field and is intended for companded traffic. In right-justified framing a 32-bit request is reduced to 24 bits. Each phase of the frame is `SLOT_BITS` bit-clock periods long. Transmit bits change after falling bit-clock edges and receive bits are taken on rising edges. The received word is presented in parallel once the frame has finished.

Top module: `audio_serial_fmt`

## Requirements
- R1: While reset is asserted and right after it, `sdout`, `adc_valid` and `adc_sample` are all 0.
- R2: The length field `wlen` encodes 00=16, 01=20, 10=24 and 11=32 bits. The transmitted word is the low L bits of `dac_sample`, sent MSB first at one bit per bit-clock period. `sdout` changes only on the system clock edge at which a falling bit-clock edge is detected.
- R3: With `wl8_en`=1 the word length is 8 bits whatever `wlen` and `fmt` hold.
- R4: With `fmt`=00 (right-justified) the LSB is the last bit of the phase, so the word starts at bit index SLOT_BITS-L. A 32-bit request in this framing behaves exactly as a 24-bit one.
- R5: With `fmt`=01 (left-justified; 11 behaves the same) the MSB is the first bit of the phase. The left phase is frame clock high.
- R6: With `fmt`=10 (I2S) the MSB is the second bit of the phase, one bit after the frame edge. The left phase is frame clock low.
- R7: `dac_swap`=0 puts the transmit word in the left phase and 1 puts it in the right phase. The other phase, and every bit outside the word, is driven 0.
- R8: `adc_swap`=0 receives from the left phase and 1 from the right phase. `sdin` is sampled on rising bit-clock edges. Bits outside the selected word do not affect the result.
- R9: At each left-phase start after the first since reset, `adc_sample` takes the word received in the previous frame, right-aligned with upper bits 0, and `adc_valid` is high for exactly one clock. The first frame after reset produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock |
| frame_i | input | 1 | Frame clock; its level selects the phase |
| fmt | input | 2 | Framing: 00 right-justified, 01 left-justified, 10 I2S |
| wlen | input | 2 | Word length field |
| wl8_en | input | 1 | Forces an 8-bit word |
| dac_swap | input | 1 | Transmit phase select |
| adc_swap | input | 1 | Receive phase select |
| dac_sample | input | 32 | Parallel transmit sample, right-aligned |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| adc_sample | output | 32 | Parallel received sample, right-aligned |
| adc_valid | output | 1 | One-clock pulse when a new received sample is presented |

## Verification
The checker watches every cycle and confirms that the serial output moves only after a detected falling bit-clock edge. It also confirms that the receive pulse is one clock wide and follows a falling edge, and that a captured sample never has bits set above 8 under the 8-bit override or above 24 in right-justified framing. Only the bench scenarios can show where each word lands inside the phase for each framing, length and swap setting. The same holds for the bit order, the zeros outside the word, the rejection of noise on `sdin`, and the absence of a pulse after the first frame.

// File: rtl/asf_pkg.sv
package asf_pkg;
   localparam int SAMPLE_W = 32;
   localparam int LEN_W    = 6;
   localparam int POS_W    = $clog2(SAMPLE_W);

   typedef enum logic [1:0] {
      FMT_RJ  = 2'b00,
      FMT_LJ  = 2'b01,
      FMT_I2S = 2'b10,
      FMT_ALT = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      WL_16 = 2'b00,
      WL_20 = 2'b01,
      WL_24 = 2'b10,
      WL_32 = 2'b11
   } wlen_e;

   typedef logic [LEN_W-1:0] len_t;

   // true when bit index idx of a phase lies inside the word
   function automatic logic slot_hit(input int idx, input int start, input int len);
      return (idx >= start) && (idx < start + len);
   endfunction

   // sample bit carried at phase index idx (MSB first)
   function automatic logic [POS_W-1:0] slot_pos(input int idx, input int start, input int len);
      int p;
      p = len - 1 - (idx - start);
      return POS_W'(p);
   endfunction
endpackage

// File: rtl/asf_len_sel.sv
module asf_len_sel
   import asf_pkg::*;
#(
   parameter int SLOT_BITS = 36,
   parameter int IDX_W     = $clog2(SLOT_BITS + 1)
) (
   input  logic [1:0]          fmt,
   input  logic [1:0]          wlen,
   input  logic                wl8_en,
   output len_t                eff_len,
   output logic [IDX_W-1:0]    start_idx,
   output logic [SAMPLE_W-1:0] len_mask,
   output logic                left_is_high
);
   fmt_e  fmt_t;
   wlen_e wlen_t;
   len_t  req_len;

   assign fmt_t  = fmt_e'(fmt);
   assign wlen_t = wlen_e'(wlen);

   always_comb begin
      unique case (wlen_t)
         WL_16:   req_len = LEN_W'(16);
         WL_20:   req_len = LEN_W'(20);
         WL_24:   req_len = LEN_W'(24);
         default: req_len = LEN_W'(32);
      endcase
   end

   // 8-bit override first, then the right-justified clamp
   always_comb begin
      if (wl8_en)
         eff_len = LEN_W'(8);
      else if (fmt_t == FMT_RJ && req_len > LEN_W'(24))
         eff_len = LEN_W'(24);
      else
         eff_len = req_len;
   end

   always_comb begin
      unique case (fmt_t)
         FMT_RJ:  start_idx = IDX_W'(SLOT_BITS - int'(eff_len));
         FMT_I2S: start_idx = IDX_W'(1);
         default: start_idx = '0;
      endcase
   end

   assign left_is_high = (fmt_t != FMT_I2S);

   for (genvar g = 0; g < SAMPLE_W; g++) begin : g_mask
      assign len_mask[g] = (LEN_W'(g) < eff_len);
   end
endmodule

// File: rtl/asf_phase.sv
module asf_phase #(
   parameter int SLOT_BITS = 36,
   parameter int IDX_W     = $clog2(SLOT_BITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             frame_i,
   input  logic             left_is_high,
   output logic             bclk_fall,
   output logic             bclk_rise,
   output logic             new_phase,
   output logic             frame_start,
   output logic [IDX_W-1:0] cur_idx,
   output logic             cur_left,
   output logic [IDX_W-1:0] idx_q,
   output logic             left_q
);
   localparam logic [IDX_W-1:0] IDX_TOP = '1;

   logic bclk_q;
   logic ph_frame;
   logic ph_seen;

   assign bclk_fall = bclk_q & ~bclk_i;
   assign bclk_rise = ~bclk_q & bclk_i;

   // a phase begins at the first falling edge or on a frame level change
   assign new_phase   = ~ph_seen | (frame_i != ph_frame);
   assign cur_left    = left_is_high ? frame_i : ~frame_i;
   assign frame_start = new_phase & cur_left;
   assign left_q      = left_is_high ? ph_frame : ~ph_frame;

   always_comb begin
      if (new_phase)
         cur_idx = '0;
      else if (idx_q == IDX_TOP)
         cur_idx = idx_q;
      else
         cur_idx = idx_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_q   <= 1'b0;
         ph_frame <= 1'b0;
         ph_seen  <= 1'b0;
         idx_q    <= '0;
      end else begin
         bclk_q <= bclk_i;
         if (bclk_fall) begin
            ph_frame <= frame_i;
            ph_seen  <= 1'b1;
            idx_q    <= cur_idx;
         end
      end
   end
endmodule

// File: rtl/asf_tx.sv
module asf_tx
   import asf_pkg::*;
#(
   parameter int SLOT_BITS = 36,
   parameter int IDX_W     = $clog2(SLOT_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_fall,
   input  logic                new_phase,
   input  logic [IDX_W-1:0]    cur_idx,
   input  logic                cur_left,
   input  logic                dac_swap,
   input  logic [SAMPLE_W-1:0] dac_sample,
   input  len_t                eff_len,
   input  logic [IDX_W-1:0]    start_idx,
   output logic                sdout
);
   logic [SAMPLE_W-1:0] hold;
   logic [SAMPLE_W-1:0] word;
   logic                active;
   logic                hit;
   logic [POS_W-1:0]    pos;
   logic                nxt_bit;

   assign active = dac_swap ? ~cur_left : cur_left;
   assign word   = new_phase ? dac_sample : hold;
   assign hit    = slot_hit(int'(cur_idx), int'(start_idx), int'(eff_len));
   assign pos    = slot_pos(int'(cur_idx), int'(start_idx), int'(eff_len));
   assign nxt_bit = (active && hit) ? word[pos] : 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sdout <= 1'b0;
         hold  <= '0;
      end else if (bclk_fall) begin
         sdout <= nxt_bit;
         if (new_phase)
            hold <= dac_sample;
      end
   end
endmodule

// File: rtl/asf_rx.sv
module asf_rx
   import asf_pkg::*;
#(
   parameter int SLOT_BITS = 36,
   parameter int IDX_W     = $clog2(SLOT_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_fall,
   input  logic                bclk_rise,
   input  logic                frame_start,
   input  logic [IDX_W-1:0]    idx_q,
   input  logic                left_q,
   input  logic                adc_swap,
   input  logic                sdin,
   input  len_t                eff_len,
   input  logic [IDX_W-1:0]    start_idx,
   input  logic [SAMPLE_W-1:0] len_mask,
   output logic [SAMPLE_W-1:0] adc_sample,
   output logic                adc_valid
);
   logic [SAMPLE_W-1:0] shreg;
   logic                started;
   logic                active;
   logic                hit;

   assign active = adc_swap ? ~left_q : left_q;
   assign hit    = slot_hit(int'(idx_q), int'(start_idx), int'(eff_len));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg      <= '0;
         started    <= 1'b0;
         adc_sample <= '0;
         adc_valid  <= 1'b0;
      end else begin
         adc_valid <= 1'b0;
         if (bclk_fall && frame_start) begin
            if (started) begin
               adc_sample <= shreg & len_mask;
               adc_valid  <= 1'b1;
            end
            started <= 1'b1;
            shreg   <= '0;
         end else if (bclk_rise && active && hit) begin
            shreg <= {shreg[SAMPLE_W-2:0], sdin};
         end
      end
   end
endmodule

// File: rtl/audio_serial_fmt.sv
module audio_serial_fmt
   import asf_pkg::*;
#(
   parameter int SLOT_BITS = 36
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bclk_i,
   input  logic        frame_i,
   input  logic [1:0]  fmt,
   input  logic [1:0]  wlen,
   input  logic        wl8_en,
   input  logic        dac_swap,
   input  logic        adc_swap,
   input  logic [31:0] dac_sample,
   input  logic        sdin,
   output logic        sdout,
   output logic [31:0] adc_sample,
   output logic        adc_valid
);
   localparam int IDX_W = $clog2(SLOT_BITS + 1);

   if (SLOT_BITS < SAMPLE_W + 1) begin : g_bad_slot
      $error("SLOT_BITS must exceed the widest word by one bit");
   end
   if (SAMPLE_W != 32) begin : g_bad_width
      $error("sample width must be 32");
   end

   len_t                eff_len;
   logic [IDX_W-1:0]    start_idx;
   logic [SAMPLE_W-1:0] len_mask;
   logic                left_is_high;
   logic                bclk_fall, bclk_rise, new_phase, frame_start;
   logic [IDX_W-1:0]    cur_idx, idx_q;
   logic                cur_left, left_q;

   asf_len_sel #(.SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W)) u_len (
      .fmt(fmt), .wlen(wlen), .wl8_en(wl8_en),
      .eff_len(eff_len), .start_idx(start_idx),
      .len_mask(len_mask), .left_is_high(left_is_high)
   );

   asf_phase #(.SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .frame_i(frame_i),
      .left_is_high(left_is_high),
      .bclk_fall(bclk_fall), .bclk_rise(bclk_rise),
      .new_phase(new_phase), .frame_start(frame_start),
      .cur_idx(cur_idx), .cur_left(cur_left),
      .idx_q(idx_q), .left_q(left_q)
   );

   asf_tx #(.SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall),
      .new_phase(new_phase), .cur_idx(cur_idx), .cur_left(cur_left),
      .dac_swap(dac_swap), .dac_sample(dac_sample),
      .eff_len(eff_len), .start_idx(start_idx), .sdout(sdout)
   );

   asf_rx #(.SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .bclk_rise(bclk_rise),
      .frame_start(frame_start), .idx_q(idx_q), .left_q(left_q),
      .adc_swap(adc_swap), .sdin(sdin),
      .eff_len(eff_len), .start_idx(start_idx), .len_mask(len_mask),
      .adc_sample(adc_sample), .adc_valid(adc_valid)
   );
endmodule

// File: rtl/asf_chk.sv
module asf_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bclk_i,
   input logic        sdout,
   input logic        adc_valid,
   input logic [31:8] adc_hi,
   input logic [1:0]  fmt,
   input logic        wl8_en
);
   logic bclk_d;
   logic fall_c;

   always_ff @(posedge clk) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= bclk_i;
   end
   assign fall_c = bclk_d & ~bclk_i;

   AST_SDOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fall_c) |-> $stable(sdout)); // R2
   AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      adc_valid |-> $past(fall_c)); // R9
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_valid |=> !adc_valid); // R9
   AST_WL8_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_valid && $past(wl8_en)) |-> (adc_hi == 24'h0)); // R3
   AST_RJ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_valid && $past(fmt) == 2'b00) |-> (adc_hi[31:24] == 8'h0)); // R4
endmodule

bind audio_serial_fmt asf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .sdout(sdout),
   .adc_valid(adc_valid), .adc_hi(adc_sample[31:8]),
   .fmt(fmt), .wl8_en(wl8_en)
);

// File: tb/tb_audio_serial_fmt.sv
module tb_audio_serial_fmt;
   localparam int SLOT = 36;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk_i = 1'b1;
   logic        frame_i = 1'b0;
   logic [1:0]  fmt = 2'b01;
   logic [1:0]  wlen = 2'b00;
   logic        wl8_en = 1'b0;
   logic        dac_swap = 1'b0;
   logic        adc_swap = 1'b0;
   logic [31:0] dac_sample = '0;
   logic        sdin = 1'b0;
   logic        sdout;
   logic [31:0] adc_sample;
   logic        adc_valid;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   audio_serial_fmt #(.SLOT_BITS(SLOT)) dut (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .frame_i(frame_i),
      .fmt(fmt), .wlen(wlen), .wl8_en(wl8_en),
      .dac_swap(dac_swap), .adc_swap(adc_swap),
      .dac_sample(dac_sample), .sdin(sdin),
      .sdout(sdout), .adc_sample(adc_sample), .adc_valid(adc_valid)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   // model of the word length rules (R2, R3, R4)
   function automatic int model_len(input logic [1:0] f, input logic [1:0] w, input logic e8);
      int n;
      if (e8) return 8;
      if (w == 2'b00)      n = 16;
      else if (w == 2'b01) n = 20;
      else if (w == 2'b10) n = 24;
      else                 n = 32;
      if (f == 2'b00 && n == 32) n = 24;
      return n;
   endfunction

   function automatic int model_start(input logic [1:0] f, input int n);
      if (f == 2'b00) return SLOT - n;
      if (f == 2'b10) return 1;
      return 0;
   endfunction

   task automatic do_reset();
      rst_n   = 1'b0;
      bclk_i  = 1'b1;
      frame_i = 1'b0;
      sdin    = 1'b0;
      repeat (4) @(negedge clk);
      check("R1", "sdout in reset", {31'b0, sdout}, 32'h0);
      check("R1", "valid in reset", {31'b0, adc_valid}, 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "sample after reset", adc_sample, 32'h0);
      check("R1", "sdout after reset", {31'b0, sdout}, 32'h0);
   endtask

   task automatic run_case(input string ttag, input string rtag,
                           input logic [1:0] f, input logic [1:0] w, input logic e8,
                           input logic dsw, input logic asw, input int nfr, input int seed);
      int          n, st;
      bit          pending;
      logic [31:0] exp_rx;
      logic        left_lvl;
      fmt = f; wlen = w; wl8_en = e8; dac_swap = dsw; adc_swap = asw;
      do_reset();
      n        = model_len(f, w, e8);
      st       = model_start(f, n);
      left_lvl = (f == 2'b10) ? 1'b0 : 1'b1;
      pending  = 1'b0;
      exp_rx   = '0;
      for (int fr = 0; fr < nfr; fr++) begin
         logic [31:0] dword, aword;
         dword = 32'hA5C3_1E96 ^ (32'(fr + seed) * 32'h1357_9BDF);
         aword = 32'h6B2D_F04C ^ (32'(fr + seed) * 32'h2468_ACE1);
         for (int p = 0; p < 2; p++) begin
            bit tq[$];
            bit rq[$];
            bit ph_left;
            ph_left = (p == 0);
            for (int b = 0; b < SLOT; b++) begin
               bit in_w;
               in_w = (b >= st) && (b < st + n);
               tq.push_back((in_w && (ph_left != dsw)) ? dword[n-1-(b-st)] : 1'b0);
               rq.push_back((in_w && (ph_left != asw)) ? aword[n-1-(b-st)] : 1'b1);
            end
            for (int b = 0; b < SLOT; b++) begin
               @(negedge clk);
               bclk_i = 1'b0;
               if (b == 0) begin
                  frame_i = ph_left ? left_lvl : ~left_lvl;
                  if (p == 0) dac_sample = dword;
               end
               sdin = rq[b];
               @(negedge clk);
               if (p == 0 && b == 0) begin
                  check("R9", "valid at frame start", {31'b0, adc_valid}, {31'b0, pending});
                  if (pending) check(rtag, "received word", adc_sample, exp_rx);
               end
               @(negedge clk);
               if (p == 0 && b == 0)
                  check("R9", "valid one clock", {31'b0, adc_valid}, 32'h0);
               check(ttag, $sformatf("sdout fr%0d ph%0d bit%0d", fr, p, b),
                     {31'b0, sdout}, {31'b0, tq[b]});
               bclk_i = 1'b1;
               @(negedge clk);
            end
         end
         pending = 1'b1;
         exp_rx  = (n == 32) ? aword : (aword & ((32'h1 << n) - 32'h1));
      end
      // flush: start one more frame to present the last received word
      @(negedge clk);
      bclk_i  = 1'b0;
      frame_i = left_lvl;
      sdin    = 1'b1;
      @(negedge clk);
      check("R9", "valid on flush", {31'b0, adc_valid}, 32'h1);
      check(rtag, "received word on flush", adc_sample, exp_rx);
      @(negedge clk);
      bclk_i = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      run_case("R5", "R9", 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 3, 1);  // left-justified 16
      run_case("R7", "R2", 2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 3, 7);  // left-justified 32, dac swapped
      run_case("R4", "R9", 2'b00, 2'b10, 1'b0, 1'b1, 1'b0, 2, 11); // right-justified 24
      run_case("R4", "R8", 2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 3, 19); // right-justified 32 clamps
      run_case("R6", "R8", 2'b10, 2'b01, 1'b0, 1'b1, 1'b1, 3, 23); // I2S 20, both swapped
      run_case("R3", "R9", 2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 2, 31); // I2S, 8-bit override
      run_case("R3", "R8", 2'b00, 2'b01, 1'b1, 1'b0, 1'b1, 2, 41); // right-justified, 8-bit override
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule